// File: doc/BRIEF.md
# Shared 64-bit Wall-Clock Timer with Periodic Comparator

This block keeps one 64-bit up-counter that every core of a cluster can read as a common time base. The counter advances once per prescaled tick. Software reaches it through a small word-addressed register port. The count is exposed as two 32-bit words. Reading the low word captures the upper half in a shadow, so the next high-word read returns a value that matches the low word already read.

A comparator watches the count. When it is enabled and the count reaches or passes a programmed 64-bit threshold, a sticky event flag is set. Software clears the flag by writing a one to it. With auto-advance on, every hit adds a programmed step to the threshold, so the event recurs at a fixed period without software taking part. The interrupt line is the event flag gated by an interrupt-enable bit.

Register words are selected by a 3-bit word index equal to the byte offset divided by four. The words are:
- index 0: count low
- index 1: count high / shadow
- index 2: control
- index 3: status
- index 4: threshold low
- index 5: threshold high
- index 6: step

Top module: `wallclock_timer`

## Requirements
- R1: After reset the count, shadow, control, status, threshold and step all read 0 and `irq` is low.
- R2: With control bit 0 (run) set and prescale value P in control bits 15:8, the count rises by one every P+1 clocks, starting from the moment run is written. With run clear it holds its value. Writes to index 0 or 1 load that half of the count.
- R3: The count is 64 bits wide and wraps from all ones to zero.
- R4: A read of index 0 copies the upper count half into a shadow. A read of index 1 returns the shadow and not the live upper half.
- R5: With control bit 1 (compare enable) set, the status flag is set on the clock after the count is greater than or equal to the threshold (unsigned). The flag then stays set.
- R6: Status bit 0 is the event flag. Writing index 3 with bit 0 = 1 clears it. Writing bit 0 = 0 leaves it unchanged.
- R7: With control bit 3 (auto-advance) and compare enable both set, each clock on which the count is at or past the threshold adds the step value to the threshold. Without auto-advance the threshold changes only when written.
- R8: `irq` is high exactly when the event flag is set and control bit 2 (interrupt enable) is set.
- R9: Writing 0 to control stops the count and stops the comparator from setting the flag.
- R10: Control reads back bits 3:0 and 15:8 as written. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_widx | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high, 0 otherwise |
| irq | output | 1 | Event interrupt |

## Verification
The assertions assume that at most one of `bus_wr` and `bus_rd` is high in any cycle and that both are low while reset is asserted. Under that assumption the count changes only by a load or by a single step. The bench drives the port only through one-cycle read and write tasks, so it never raises both strobes together. Every count, prescale and threshold scenario starts from a count loaded while the counter is stopped, which keeps the expected value a closed-form function of the number of clocks it ran.

// File: rtl/wct_pkg.sv
package wct_pkg;
  localparam int PRESC_W = 8;

  typedef enum logic [2:0] {
    IDX_CNT_LO = 3'd0,
    IDX_CNT_HI = 3'd1,
    IDX_CTRL   = 3'd2,
    IDX_STAT   = 3'd3,
    IDX_THR_LO = 3'd4,
    IDX_THR_HI = 3'd5,
    IDX_STEP   = 3'd6
  } reg_idx_e;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               auto_adv;
    logic               irq_en;
    logic               cmp_en;
    logic               run;
  } ctrl_t;
endpackage

// File: rtl/wct_rst_sync.sv
module wct_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/wct_prescaler.sv
module wct_prescaler #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] limit,
  output logic               tick
);
  logic [PRESC_W-1:0] div_q, div_d;

  always_comb begin
    tick  = run && (div_q == limit);
    div_d = div_q;
    if (!run || tick) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/wct_counter.sv
module wct_counter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [DATA_W-1:0] ld_data,
  output logic [CNT_W-1:0]  count
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = ld_lo || ld_hi || tick;
    cnt_d  = cnt_q;
    if (ld_lo) begin
      cnt_d = {cnt_q[CNT_W-1:HALF], ld_data[HALF-1:0]};
    end else if (ld_hi) begin
      cnt_d = {ld_data[HALF-1:0], cnt_q[HALF-1:0]};
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/wct_comparator.sv
module wct_comparator #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic              cmp_en,
  input  logic              auto_adv,
  input  logic              wr_thr_lo,
  input  logic              wr_thr_hi,
  input  logic              wr_step,
  input  logic              clr_flag,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  threshold,
  output logic [DATA_W-1:0] step,
  output logic              flag
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0]  thr_q, thr_d;
  logic [DATA_W-1:0] step_q;
  logic              flag_q, flag_d;
  logic              hit;
  logic              thr_ce;

  always_comb begin
    hit    = cmp_en && (count >= thr_q);
    thr_ce = wr_thr_lo || wr_thr_hi || (hit && auto_adv);
    thr_d  = thr_q;
    if (wr_thr_lo) begin
      thr_d = {thr_q[CNT_W-1:HALF], wdata[HALF-1:0]};
    end else if (wr_thr_hi) begin
      thr_d = {wdata[HALF-1:0], thr_q[HALF-1:0]};
    end else if (hit && auto_adv) begin
      thr_d = thr_q + {{(CNT_W-DATA_W){1'b0}}, step_q};
    end
    flag_d = flag_q;
    if (hit) begin
      flag_d = 1'b1;
    end else if (clr_flag) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= '0;
      step_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (thr_ce) begin
        thr_q <= thr_d;
      end
      if (wr_step) begin
        step_q <= wdata;
      end
      flag_q <= flag_d;
    end
  end

  assign threshold = thr_q;
  assign step      = step_q;
  assign flag      = flag_q;
endmodule

// File: rtl/wallclock_timer.sv
module wallclock_timer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [IDX_W-1:0]  bus_widx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import wct_pkg::*;

  localparam int HALF   = CNT_W / 2;
  localparam int CTRL_W = $bits(ctrl_t);

  logic              rst_sync_n;
  ctrl_t             ctrl_q, ctrl_d;
  logic [HALF-1:0]   shadow_q;
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  thr_q;
  logic [DATA_W-1:0] step_q;
  logic              flag_q;
  logic              tick;
  logic              wr_cnt_lo, wr_cnt_hi, wr_ctrl, wr_thr_lo, wr_thr_hi;
  logic              wr_step, clr_flag, rd_cnt_lo;
  reg_idx_e          idx;

  wct_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    idx       = reg_idx_e'(bus_widx);
    wr_cnt_lo = bus_wr && (idx == IDX_CNT_LO);
    wr_cnt_hi = bus_wr && (idx == IDX_CNT_HI);
    wr_ctrl   = bus_wr && (idx == IDX_CTRL);
    clr_flag  = bus_wr && (idx == IDX_STAT) && bus_wdata[0];
    wr_thr_lo = bus_wr && (idx == IDX_THR_LO);
    wr_thr_hi = bus_wr && (idx == IDX_THR_HI);
    wr_step   = bus_wr && (idx == IDX_STEP);
    rd_cnt_lo = bus_rd && (idx == IDX_CNT_LO);
    ctrl_d    = '{presc:    bus_wdata[PRESC_W+7:8],
                  auto_adv: bus_wdata[3],
                  irq_en:   bus_wdata[2],
                  cmp_en:   bus_wdata[1],
                  run:      bus_wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      shadow_q <= '0;
    end else if (rd_cnt_lo) begin
      shadow_q <= count_q[CNT_W-1:HALF];
    end
  end

  wct_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (ctrl_q.run),
    .limit (ctrl_q.presc),
    .tick  (tick)
  );

  wct_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick),
    .ld_lo   (wr_cnt_lo),
    .ld_hi   (wr_cnt_hi),
    .ld_data (bus_wdata),
    .count   (count_q)
  );

  wct_comparator #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .count     (count_q),
    .cmp_en    (ctrl_q.cmp_en),
    .auto_adv  (ctrl_q.auto_adv),
    .wr_thr_lo (wr_thr_lo),
    .wr_thr_hi (wr_thr_hi),
    .wr_step   (wr_step),
    .clr_flag  (clr_flag),
    .wdata     (bus_wdata),
    .threshold (thr_q),
    .step      (step_q),
    .flag      (flag_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (idx)
        IDX_CNT_LO: bus_rdata = count_q[HALF-1:0];
        IDX_CNT_HI: bus_rdata = shadow_q;
        IDX_CTRL:   bus_rdata = {{(DATA_W-CTRL_W-4){1'b0}}, ctrl_q.presc,
                                 4'b0000, ctrl_q.auto_adv, ctrl_q.irq_en,
                                 ctrl_q.cmp_en, ctrl_q.run};
        IDX_STAT:   bus_rdata = {{(DATA_W-1){1'b0}}, flag_q};
        IDX_THR_LO: bus_rdata = thr_q[HALF-1:0];
        IDX_THR_HI: bus_rdata = thr_q[CNT_W-1:HALF];
        IDX_STEP:   bus_rdata = step_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq = flag_q && ctrl_q.irq_en;
endmodule

// File: rtl/wct_checker.sv
module wct_checker #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] threshold,
  input logic [CNT_W/2-1:0] shadow,
  input logic             run,
  input logic             cmp_en,
  input logic             auto_adv,
  input logic             wr_cnt,
  input logic             wr_thr,
  input logic             rd_lo,
  input logic             clr,
  input logic             flag,
  input logic             irq
);
  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> (count == $past(count)));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt) |=> (count == $past(count) || count == $past(count) + 1'b1));

  assert_shadow_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (shadow == $past(count[CNT_W-1:CNT_W/2])));

  assert_sticky_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  assert_thr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(auto_adv && cmp_en) && !wr_thr) |=> $stable(threshold));

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !irq);

  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !cmp_en) |=> !flag);
endmodule

bind wallclock_timer wct_checker #(.CNT_W(CNT_W)) u_wct_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .count     (count_q),
  .threshold (thr_q),
  .shadow    (shadow_q),
  .run       (ctrl_q.run),
  .cmp_en    (ctrl_q.cmp_en),
  .auto_adv  (ctrl_q.auto_adv),
  .wr_cnt    (wr_cnt_lo || wr_cnt_hi),
  .wr_thr    (wr_thr_lo || wr_thr_hi),
  .rd_lo     (rd_cnt_lo),
  .clr       (clr_flag),
  .flag      (flag_q),
  .irq       (irq)
);

// File: tb/wallclock_timer_bench.sv
module wallclock_timer_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [2:0]  bus_widx;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks   = 0;
  int failures = 0;
  logic done = 1'b0;

  wallclock_timer u_wallclock_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_widx  (bus_widx),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] data);
    bus_wr = 1'b1; bus_widx = idx; bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] data);
    bus_rd = 1'b1; bus_widx = idx;
    #1 data = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_count(input logic [63:0] start, input int edges, input int presc);
    return start + 64'(edges / (presc + 1));
  endfunction

  function automatic logic [63:0] exp_thr(input logic [63:0] thr0, input logic [63:0] step, input int edges);
    logic [63:0] c = 0;
    logic [63:0] t = thr0;
    for (int e = 0; e < edges; e++) begin
      if (c >= t) t = t + step;
      c = c + 1;
    end
    return t;
  endfunction

  initial begin
    logic [31:0] lo, hi, d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_widx = '0; bus_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int i = 0; i < 7; i++) begin
      rd(3'(i), d);
      chk("R1", {32'd0, d}, 64'd0);
    end
    chk("R1 irq", {63'd0, irq}, 64'd0);

    // R10 control readback
    wr(3'd2, 32'hFFFF_FFF0);
    rd(3'd2, d);
    chk("R10", {32'd0, d}, 64'h0000_FF00);
    wr(3'd2, 32'h0);

    // R3 wrap
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h1);
    wr(3'd2, 32'h0);
    rd(3'd0, lo); rd(3'd1, hi);
    chk("R3", {hi, lo}, 64'd0);

    // R4 shadow vs live upper half
    wr(3'd1, 32'd5);
    rd(3'd0, lo);
    wr(3'd1, 32'd9);
    rd(3'd1, hi);
    chk("R4 shadow", {32'd0, hi}, 64'd5);
    rd(3'd0, lo); rd(3'd1, hi);
    chk("R4 refresh", {32'd0, hi}, 64'd9);

    // R2 random prescale and run lengths
    for (int it = 0; it < 10; it++) begin
      int p, m;
      logic [63:0] st;
      p  = int'($urandom % 8);
      m  = int'($urandom % 50);
      st = {32'($urandom % 16), $urandom};
      wr(3'd0, st[31:0]);
      wr(3'd1, st[63:32]);
      wr(3'd2, (32'(p) << 8) | 32'h1);
      idle(m);
      wr(3'd2, 32'h0);
      rd(3'd0, lo); rd(3'd1, hi);
      chk("R2", {hi, lo}, exp_count(st, m + 1, p));
    end
    // R2 and R9: stopped counter holds
    idle(5);
    rd(3'd0, d);
    chk("R9 hold", {32'd0, d}, 64'(lo));

    // R5 compare flag timing
    wr(3'd0, 32'd0); wr(3'd1, 32'd0);
    wr(3'd4, 32'd10); wr(3'd5, 32'd0);
    wr(3'd2, 32'h3);
    idle(8);
    rd(3'd3, d);
    chk("R5 before", {32'd0, d}, 64'd0);
    idle(2);
    rd(3'd3, d);
    chk("R5 after", {32'd0, d}, 64'd1);
    wr(3'd2, 32'h0);
    chk("R8 masked", {63'd0, irq}, 64'd0);
    wr(3'd2, 32'h4);
    chk("R8 enabled", {63'd0, irq}, 64'd1);

    // R6 write-one-to-clear
    wr(3'd3, 32'hFFFF_FFFE);
    rd(3'd3, d);
    chk("R6 zero write", {32'd0, d}, 64'd1);
    wr(3'd3, 32'h1);
    rd(3'd3, d);
    chk("R6 clear", {32'd0, d}, 64'd0);
    chk("R8 cleared", {63'd0, irq}, 64'd0);
    idle(3);
    rd(3'd3, d);
    chk("R9 no compare", {32'd0, d}, 64'd0);

    // R7 auto-advance
    wr(3'd2, 32'h0);
    wr(3'd0, 32'd0); wr(3'd1, 32'd0);
    wr(3'd4, 32'd4); wr(3'd6, 32'd5);
    wr(3'd3, 32'h1);
    wr(3'd2, 32'hB);
    idle(11);
    wr(3'd2, 32'h0);
    rd(3'd4, d);
    chk("R7 threshold", {32'd0, d}, exp_thr(64'd4, 64'd5, 12));
    rd(3'd0, d);
    chk("R7 count", {32'd0, d}, 64'd12);
    rd(3'd3, d);
    chk("R7 flag", {32'd0, d}, 64'd1);
    idle(3);
    rd(3'd4, d);
    chk("R7 hold", {32'd0, d}, exp_thr(64'd4, 64'd5, 12));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule